// File: doc/BRIEF.md
# Two-Operand Averaging Controller

This block computes the integer mean of two unsigned numbers that arrive one after the other on a single shared data bus. A one-cycle start strobe opens a request. The first operand sits on the bus in the cycle that follows the strobe, and the second operand sits on the bus in the cycle after that. A small sequencer then steps a four-function arithmetic unit through three operations, one per clock: capture, sum and halve. All three work on one accumulator that is one bit wider than the data, so the carry of the sum is never lost.

When the halved value is in the accumulator, the sequencer raises a completion flag. The result and the flag hold until the next start strobe. That strobe drops the flag and begins the next request at once. The design is fully synchronous, apart from an active-high reset that clears it at any time. The controller is a two-process machine with enumerated states.

Top module: `avg_unit`

## Requirements
- R1: While reset is high, and after it is released with no strobe, `fin` is 0 and `result` is 0. Reset acts at once, without waiting for a clock edge, and it aborts a computation in progress.
- R2: A strobe sampled high at edge E0 makes the block capture `data_in` at edge E1 as the first operand and at edge E2 as the second operand. `fin` rises after edge E3. The value on `data_in` during the strobe cycle is not used.
- R3: With `fin` high, `result` equals floor((x + y) / 2) for every pair of unsigned WIDTH-bit operands, including operands at the all-ones maximum. The intermediate sum keeps its carry in a WIDTH+1-bit accumulator.
- R4: The internal opcode uses the encoding 00 = A + B, 01 = A shifted right by one bit, 10 = pass B, 11 = pass A. A is the accumulator and B is the zero-extended data bus. Each request issues pass B, then add, then shift, on three consecutive cycles.
- R5: While `fin` is high and no strobe arrives, `fin` stays 1 and `result` stays unchanged, however many cycles pass.
- R6: A strobe that arrives while `fin` is high drops `fin` on the next cycle and starts a new request with the same timing as R2.
- R7: A strobe that arrives during the capture, sum or halve cycles is ignored. The result and the timing of `fin` are the same as without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| go | input | 1 | One-cycle start strobe |
| data_in | input | WIDTH | Operand bus, first then second operand |
| result | output | WIDTH | Averaged value, valid while fin is high |
| fin | output | 1 | Result-valid flag |

## Verification
The assertions assume that `go` is a single-cycle pulse, and that the operands sit on `data_in` in exactly the two cycles that follow it. They do not assume that `go` stays low during a computation: the strobe is allowed to land mid-sequence, and that is the case R7 covers. The stimulus changes inputs only on falling edges. It sweeps every operand pair of a 4-bit instance. It varies how many idle cycles separate one request from the next, puts junk on the bus in the cycles that must be ignored, and fires stray strobes in the sum cycle.

// File: rtl/avg_pkg.sv
package avg_pkg;

  typedef enum logic [1:0] {
    OP_ADD   = 2'b00,
    OP_SHR   = 2'b01,
    OP_PASSB = 2'b10,
    OP_PASSA = 2'b11
  } avg_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADD,
    ST_SHIFT,
    ST_DONE
  } avg_state_e;

endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  output logic [1:0] op,
  output logic       acc_en,
  output logic       fin
);

  avg_state_e state_q, state_d;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    op      = OP_PASSA;
    acc_en  = 1'b0;
    fin     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        op      = OP_PASSB;
        acc_en  = 1'b1;
        state_d = ST_ADD;
      end
      ST_ADD: begin
        op      = OP_ADD;
        acc_en  = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        op      = OP_SHR;
        acc_en  = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        fin = 1'b1;
        if (go) state_d = ST_LOAD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/avg_alu.sv
module avg_alu
  import avg_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = WIDTH + 1
) (
  input  logic [AW-1:0]    a,
  input  logic [WIDTH-1:0] b,
  input  logic [1:0]       op,
  output logic [AW-1:0]    y
);

  function automatic logic [AW-1:0] alu_eval(input logic [AW-1:0] fa,
                                             input logic [WIDTH-1:0] fb,
                                             input logic [1:0] fop);
    logic [AW-1:0] bx;
    bx = {1'b0, fb};
    case (fop)
      OP_ADD:   return fa + bx;
      OP_SHR:   return fa >> 1;
      OP_PASSB: return bx;
      default:  return fa;
    endcase
  endfunction

  assign y = alu_eval(a, b, op);

endmodule

// File: rtl/avg_acc.sv
module avg_acc #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/avg_unit.sv
module avg_unit
  import avg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] result,
  output logic             fin
);

  localparam int AW = WIDTH + 1;

  logic [1:0]    alu_op;
  logic          acc_en;
  logic [AW-1:0] acc_q;
  logic [AW-1:0] alu_y;

  avg_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .go     (go),
    .op     (alu_op),
    .acc_en (acc_en),
    .fin    (fin)
  );

  avg_alu #(.WIDTH(WIDTH)) u_alu (
    .a  (acc_q),
    .b  (data_in),
    .op (alu_op),
    .y  (alu_y)
  );

  avg_acc #(.AW(AW)) u_acc (
    .clk (clk),
    .rst (rst),
    .en  (acc_en),
    .d   (alu_y),
    .q   (acc_q)
  );

  assign result = acc_q[WIDTH-1:0];

endmodule

// File: rtl/avg_unit_chk.sv
module avg_unit_chk
  import avg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             go,
  input logic             fin,
  input logic [WIDTH-1:0] result,
  input logic [1:0]       op,
  input logic             acc_en,
  input logic [WIDTH:0]   acc_q
);

  // R4
  load_then_add_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && op == OP_PASSB) |=> (acc_en && op == OP_ADD));

  // R7
  add_then_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && op == OP_ADD) |=> (acc_en && op == OP_SHR && !fin));

  // R2
  shift_then_fin_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && op == OP_SHR) |=> fin);

  // R5
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && !go) |=> (fin && $stable(result)));

  // R6
  fin_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (fin && go) |=> (!fin && acc_en && op == OP_PASSB));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fin |-> (acc_q[WIDTH] == 1'b0));

endmodule

bind avg_unit avg_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .go     (go),
  .fin    (fin),
  .result (result),
  .op     (alu_op),
  .acc_en (acc_en),
  .acc_q  (acc_q)
);

// File: tb/avg_unit_bench.sv
module avg_unit_bench;

  localparam int W = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         go = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] result;
  logic         fin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  avg_unit #(.WIDTH(W)) u_avg_unit (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .data_in (data_in),
    .result  (result),
    .fin     (fin)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // One request; stray puts a strobe into the sum cycle (R7)
  task automatic run(input int x, input int y, input bit stray, input int idle);
    int expv;
    bit was_fin;
    expv = (x + y) / 2;
    was_fin = fin;
    @(negedge clk);
    go = 1'b1; data_in = W'(~x);            // junk in strobe cycle (R2)
    @(negedge clk);                          // LOAD cycle
    go = 1'b0; data_in = W'(x);
    if (was_fin) chk("R6 fin drop", int'(fin), 0);
    @(negedge clk);                          // ADD cycle
    data_in = W'(y);
    go = stray;
    chk("R2 fin low mid", int'(fin), 0);
    @(negedge clk);                          // SHIFT cycle
    go = 1'b0; data_in = W'(x ^ y ^ MAXV);
    chk(stray ? "R7 fin low" : "R2 fin low", int'(fin), 0);
    @(negedge clk);                          // DONE
    chk(stray ? "R7 fin" : "R2 fin", int'(fin), 1);
    chk(stray ? "R7 result" : "R3 R4 result", int'(result), expv);
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      data_in = W'(i);
    end
    if (idle > 0) begin
      chk("R5 hold fin", int'(fin), 1);
      chk("R5 hold result", int'(result), expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3 + 2);
    chk("R1 reset fin", int'(fin), 0);
    chk("R1 reset result", int'(result), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 idle fin", int'(fin), 0);
    chk("R1 idle result", int'(result), 0);

    for (int x = 0; x <= MAXV; x++) begin
      for (int y = 0; y <= MAXV; y++) begin
        run(x, y, ((x + y) % 5) == 0, (x * 3 + y) % 4);
      end
    end
    run(MAXV, MAXV, 1'b0, 6);
    run(MAXV, MAXV, 1'b1, 2);

    // R1: asynchronous reset mid-computation
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0; data_in = W'(MAXV);
    @(negedge clk);
    data_in = W'(MAXV);
    #2 rst = 1'b1;
    #1;
    chk("R1 async fin", int'(fin), 0);
    chk("R1 async result", int'(result), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 post-abort fin", int'(fin), 0);
    run(9, 4, 1'b0, 1);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule